// File: doc/BRIEF.md
# Multi-Cycle 32-bit Integer Divider with Quotient/Remainder Select

This block divides one 32-bit operand by another and returns either the quotient or the remainder. Two mode inputs choose remainder versus quotient and signed versus unsigned interpretation. A caller raises `start_i` for one cycle with the operands and modes. The block reports `busy_o` while it iterates and pulses `done_o` when `result_o` carries the answer. The 32-bit answer is always widened to a 64-bit word by copying its bit 31 into the upper half.

The datapath is a radix-2 restoring divider that works on operand magnitudes and fixes signs after the last iteration. Signed division truncates toward zero, and a signed remainder takes the sign of the dividend. Two cases never enter the iteration loop: a zero divisor, and the signed overflow case (most negative value divided by minus one). Both return fixed values one cycle after acceptance and never raise a fault.

Top module: `word_divider`

## Requirements
- R1: A request is accepted on a rising edge where `start_i` is 1 and `busy_o` is 0. For a regular operation, `busy_o` is 1 from the next cycle on. `start_i` has no effect while `busy_o` is 1.
- R2: For a regular operation, `busy_o` stays high for exactly 32 cycles. `done_o` is 1 in the cycle in which `busy_o` returns to 0, which is 33 cycles after the accepting edge.
- R3: With `want_rem_i`=0 the result is the quotient. With `signed_i`=1 it is a two's-complement quotient truncated toward zero; with `signed_i`=0 it is the unsigned quotient.
- R4: With `want_rem_i`=1 the result is the remainder r, where dividend = quotient*divisor + r. In signed mode r is zero or has the sign of the dividend.
- R5: A divisor of 0 yields 0x80000000 for a quotient (signed or unsigned) and 0 for a remainder. `done_o` is 1 in the cycle right after acceptance, and `busy_o` stays 0.
- R6: In signed mode, a dividend of 0x80000000 with divisor 0xFFFFFFFF yields quotient 0x80000000 and remainder 0, with the one-cycle timing of R5. In unsigned mode the same operands are a regular operation.
- R7: `result_o[63:32]` always equals 32 copies of `result_o[31]`, in both signed and unsigned modes.
- R8: `done_o` is a single-cycle pulse for each accepted operation. `result_o` changes only in a cycle where `done_o` is 1 and holds its value until the next completion. After reset `busy_o`, `done_o` and `result_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Request strobe, taken when not busy |
| op_a_i | input | 32 | Dividend |
| op_b_i | input | 32 | Divisor |
| want_rem_i | input | 1 | 1 selects remainder, 0 selects quotient |
| signed_i | input | 1 | 1 selects two's-complement operands, 0 unsigned |
| busy_o | output | 1 | Iteration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | 64 | Sign-extended 32-bit result |

## Verification
Each kind of internal fault shows up at a predictable point on the ports:

- A corrupted iteration counter shifts the rise of `done_o` away from the 33rd cycle, so a latency check catches it at the end of the first operation.
- A wrong partial remainder or quotient bit does not show up until completion. It then appears as a wrong quotient or remainder, which the bench compares against a model that divides the same operands.
- A sign-fix fault shows only for operands with mixed signs.
- A special-case detection fault shows as either a wrong fixed value, or a 33-cycle latency where a single cycle was expected.

// File: rtl/divmod_pkg.sv
package divmod_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } div_state_t;

  // Fixed answer for a zero divisor or signed overflow, quotient side.
  function automatic logic [31:0] min_word();
    return 32'h8000_0000;
  endfunction

endpackage

// File: rtl/divmod_prep.sv
// Operand conditioning: magnitudes, sign flags and special-case detection.
module divmod_prep #(
  parameter int W = 32
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sgn_i,
  output logic [W-1:0] mag_a_o,
  output logic [W-1:0] mag_b_o,
  output logic         neg_a_o,
  output logic         neg_b_o,
  output logic         zero_div_o,
  output logic         ovf_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0] ALL_ONES = {W{1'b1}};

  always_comb begin
    neg_a_o    = sgn_i & a_i[W-1];
    neg_b_o    = sgn_i & b_i[W-1];
    mag_a_o    = neg_a_o ? (~a_i + 1'b1) : a_i;
    mag_b_o    = neg_b_o ? (~b_i + 1'b1) : b_i;
    zero_div_o = (b_i == '0);
    ovf_o      = sgn_i & (a_i == MOST_NEG) & (b_i == ALL_ONES);
  end
endmodule

// File: rtl/divmod_step.sv
// One restoring iteration: shift in a dividend bit, try to subtract.
module divmod_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] rem_i,
  input  logic [W-1:0] quo_i,
  input  logic [W-1:0] div_i,
  output logic [W-1:0] rem_o,
  output logic [W-1:0] quo_o
);
  logic [W:0] trial;
  logic [W:0] diff;
  logic       fits;

  always_comb begin
    trial = {rem_i, quo_i[W-1]};
    diff  = trial - {1'b0, div_i};
    fits  = ~diff[W];
    rem_o = fits ? diff[W-1:0] : trial[W-1:0];
    quo_o = {quo_i[W-2:0], fits};
  end
endmodule

// File: rtl/divmod_post.sv
// Sign restoration, special-value substitution and widening.
module divmod_post #(
  parameter int W  = 32,
  parameter int OW = 64
) (
  input  logic [W-1:0]  quo_mag_i,
  input  logic [W-1:0]  rem_mag_i,
  input  logic          neg_q_i,
  input  logic          neg_r_i,
  input  logic          want_rem_i,
  input  logic          fixed_i,
  output logic [OW-1:0] res_o
);
  localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

  logic [W-1:0] word;

  always_comb begin
    if (fixed_i) begin
      word = want_rem_i ? '0 : MOST_NEG;
    end else if (want_rem_i) begin
      word = neg_r_i ? (~rem_mag_i + 1'b1) : rem_mag_i;
    end else begin
      word = neg_q_i ? (~quo_mag_i + 1'b1) : quo_mag_i;
    end
    res_o = {{(OW-W){word[W-1]}}, word};
  end
endmodule

// File: rtl/word_divider.sv
module word_divider #(
  parameter int W     = 32,
  parameter int OW    = 64,
  parameter int STEPS = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic [W-1:0]  op_a_i,
  input  logic [W-1:0]  op_b_i,
  input  logic          want_rem_i,
  input  logic          signed_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [OW-1:0] result_o
);
  import divmod_pkg::*;

  localparam int ITER  = W / STEPS;
  localparam int CNT_W = (ITER > 1) ? $clog2(ITER) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ITER - 1);

  // reset: asynchronous assert, synchronous release
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  div_state_t       state_q, state_d;
  logic [W-1:0]     rem_q, rem_d;
  logic [W-1:0]     quo_q, quo_d;
  logic [W-1:0]     div_q, div_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             neg_q_q, neg_q_d;
  logic             neg_r_q, neg_r_d;
  logic             mode_rem_q, mode_rem_d;
  logic             done_q, done_d;
  logic [OW-1:0]    res_q, res_d;
  logic             dp_en, res_en;

  logic [W-1:0] mag_a, mag_b;
  logic         neg_a, neg_b, zero_div, ovf, fixed_case, accept;

  divmod_prep #(.W(W)) u_prep (
    .a_i        (op_a_i),
    .b_i        (op_b_i),
    .sgn_i      (signed_i),
    .mag_a_o    (mag_a),
    .mag_b_o    (mag_b),
    .neg_a_o    (neg_a),
    .neg_b_o    (neg_b),
    .zero_div_o (zero_div),
    .ovf_o      (ovf)
  );

  // iteration chain, STEPS restoring stages per clock
  logic [W-1:0] rem_chain [STEPS+1];
  logic [W-1:0] quo_chain [STEPS+1];
  assign rem_chain[0] = rem_q;
  assign quo_chain[0] = quo_q;

  for (genvar g = 0; g < STEPS; g++) begin : g_stage
    divmod_step #(.W(W)) u_step (
      .rem_i (rem_chain[g]),
      .quo_i (quo_chain[g]),
      .div_i (div_q),
      .rem_o (rem_chain[g+1]),
      .quo_o (quo_chain[g+1])
    );
  end

  // the post stage sees live flags when idle, latched values when running
  logic          running;
  logic          post_neg_q, post_neg_r, post_rem, post_fixed;
  logic [OW-1:0] post_res;

  always_comb begin
    running    = (state_q == ST_RUN);
    post_neg_q = running ? neg_q_q    : 1'b0;
    post_neg_r = running ? neg_r_q    : 1'b0;
    post_rem   = running ? mode_rem_q : want_rem_i;
    post_fixed = running ? 1'b0       : fixed_case;
  end

  divmod_post #(.W(W), .OW(OW)) u_post (
    .quo_mag_i  (quo_chain[STEPS]),
    .rem_mag_i  (rem_chain[STEPS]),
    .neg_q_i    (post_neg_q),
    .neg_r_i    (post_neg_r),
    .want_rem_i (post_rem),
    .fixed_i    (post_fixed),
    .res_o      (post_res)
  );

  // next-state logic
  always_comb begin
    fixed_case = zero_div | ovf;
    accept     = start_i & (state_q == ST_IDLE);
    state_d    = state_q;
    rem_d      = rem_q;
    quo_d      = quo_q;
    div_d      = div_q;
    cnt_d      = cnt_q;
    neg_q_d    = neg_q_q;
    neg_r_d    = neg_r_q;
    mode_rem_d = mode_rem_q;
    res_d      = res_q;
    done_d     = 1'b0;
    dp_en      = 1'b0;
    res_en     = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          if (fixed_case) begin
            res_d  = post_res;
            res_en = 1'b1;
            done_d = 1'b1;
          end else begin
            state_d    = ST_RUN;
            dp_en      = 1'b1;
            rem_d      = '0;
            quo_d      = mag_a;
            div_d      = mag_b;
            cnt_d      = CNT_LAST;
            neg_q_d    = neg_a ^ neg_b;
            neg_r_d    = neg_a;
            mode_rem_d = want_rem_i;
          end
        end
      end
      ST_RUN: begin
        dp_en = 1'b1;
        rem_d = rem_chain[STEPS];
        quo_d = quo_chain[STEPS];
        cnt_d = cnt_q - 1'b1;
        if (cnt_q == '0) begin
          state_d = ST_IDLE;
          res_d   = post_res;
          res_en  = 1'b1;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  // registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      rem_q      <= '0;
      quo_q      <= '0;
      div_q      <= '0;
      cnt_q      <= '0;
      neg_q_q    <= 1'b0;
      neg_r_q    <= 1'b0;
      mode_rem_q <= 1'b0;
    end else if (dp_en) begin
      rem_q      <= rem_d;
      quo_q      <= quo_d;
      div_q      <= div_d;
      cnt_q      <= cnt_d;
      neg_q_q    <= neg_q_d;
      neg_r_q    <= neg_r_d;
      mode_rem_q <= mode_rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else if (res_en) begin
      res_q <= res_d;
    end
  end

  assign busy_o   = (state_q == ST_RUN);
  assign done_o   = done_q;
  assign result_o = res_q;

endmodule

// File: rtl/divmod_chk.sv
module divmod_chk #(
  parameter int W    = 32,
  parameter int OW   = 64,
  parameter int ITER = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start_i,
  input logic [W-1:0]  op_a_i,
  input logic [W-1:0]  op_b_i,
  input logic          want_rem_i,
  input logic          signed_i,
  input logic          busy_o,
  input logic          done_o,
  input logic [OW-1:0] result_o
);
  localparam logic [W-1:0]  MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic [OW-1:0] Q_FIXED  = {{(OW-W+1){1'b1}}, {(W-1){1'b0}}};
  localparam int            RC_W     = $clog2(ITER + 1);

  logic [RC_W-1:0] run_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      run_cnt <= '0;
    else if (busy_o) run_cnt <= run_cnt + 1'b1;
    else             run_cnt <= '0;
  end

  logic take, fixed_in;
  assign take     = start_i & ~busy_o;
  assign fixed_in = (op_b_i == '0) |
                    (signed_i & (op_a_i == MOST_NEG) & (op_b_i == {W{1'b1}}));

  // R1: a regular request starts the iteration
  a_r1_accept_busy: assert property (@(posedge clk) disable iff (!rst_n)
    take && !fixed_in |=> busy_o);

  // R2: busy lasts exactly ITER cycles and ends together with done
  a_r2_busy_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> run_cnt < RC_W'(ITER));
  a_r2_finish: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && run_cnt == RC_W'(ITER - 1) |=> !busy_o && done_o);

  // R5: zero divisor answers in one cycle
  a_r5_zero_quo: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_b_i == '0 && !want_rem_i |=> done_o && !busy_o && result_o == Q_FIXED);
  a_r5_zero_rem: assert property (@(posedge clk) disable iff (!rst_n)
    take && op_b_i == '0 && want_rem_i |=> done_o && !busy_o && result_o == '0);

  // R6: signed overflow answers in one cycle
  a_r6_ovf_quo: assert property (@(posedge clk) disable iff (!rst_n)
    take && signed_i && op_a_i == MOST_NEG && op_b_i == {W{1'b1}} && !want_rem_i
    |=> done_o && result_o == Q_FIXED);

  // R7: upper half is a copy of bit W-1
  a_r7_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
    result_o[OW-1:W] == {(OW-W){result_o[W-1]}});

  // R8: result moves only with done, done is a pulse unless restarted
  a_r8_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result_o) |-> done_o);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done_o && !start_i |=> !done_o);
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> !busy_o);

endmodule

bind word_divider divmod_chk #(.W(W), .OW(OW), .ITER(ITER)) u_divmod_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start_i    (start_i),
  .op_a_i     (op_a_i),
  .op_b_i     (op_b_i),
  .want_rem_i (want_rem_i),
  .signed_i   (signed_i),
  .busy_o     (busy_o),
  .done_o     (done_o),
  .result_o   (result_o)
);

// File: tb/word_divider_tb_top.sv
module word_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start_i;
  logic [31:0] op_a_i, op_b_i;
  logic        want_rem_i, signed_i;
  logic        busy_o, done_o;
  logic [63:0] result_o;

  int n_checks = 0;
  int n_fails  = 0;

  always #5 clk = ~clk;

  word_divider dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (start_i),
    .op_a_i     (op_a_i),
    .op_b_i     (op_b_i),
    .want_rem_i (want_rem_i),
    .signed_i   (signed_i),
    .busy_o     (busy_o),
    .done_o     (done_o),
    .result_o   (result_o)
  );

  // vector: {dividend, divisor, want_rem, signed}
  localparam int NV = 22;
  localparam logic [65:0] VECS [NV] = '{
    {32'd100,        32'd7,          1'b0, 1'b0},
    {32'd100,        32'd7,          1'b1, 1'b0},
    {-32'sd100,      32'd7,          1'b0, 1'b1},
    {-32'sd100,      32'd7,          1'b1, 1'b1},
    {32'd100,        -32'sd7,        1'b0, 1'b1},
    {32'd100,        -32'sd7,        1'b1, 1'b1},
    {-32'sd100,      -32'sd7,        1'b0, 1'b1},
    {-32'sd100,      -32'sd7,        1'b1, 1'b1},
    {32'hFFFF_FFFF,  32'd1,          1'b0, 1'b0},
    {32'hFFFF_FFFF,  32'hFFFF_FFFF,  1'b0, 1'b0},
    {32'hFFFF_FFFF,  32'd16,         1'b1, 1'b0},
    {32'd12345,      32'd0,          1'b0, 1'b1},
    {32'd12345,      32'd0,          1'b0, 1'b0},
    {32'd12345,      32'd0,          1'b1, 1'b1},
    {32'd12345,      32'd0,          1'b1, 1'b0},
    {32'h8000_0000,  32'hFFFF_FFFF,  1'b0, 1'b1},
    {32'h8000_0000,  32'hFFFF_FFFF,  1'b1, 1'b1},
    {32'h8000_0000,  32'hFFFF_FFFF,  1'b0, 1'b0},
    {32'h8000_0000,  32'd1,          1'b0, 1'b1},
    {32'd7,          32'd100,        1'b0, 1'b0},
    {32'd7,          32'd100,        1'b1, 1'b0},
    {32'h8000_0000,  32'd2,          1'b1, 1'b1}
  };

  function automatic logic [63:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic rem, input logic sgn);
    logic [31:0] w;
    int sa, sb;
    sa = int'(a);
    sb = int'(b);
    if (b == 32'd0)                                        w = rem ? 32'd0 : 32'h8000_0000;
    else if (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF) w = rem ? 32'd0 : 32'h8000_0000;
    else if (sgn)                                          w = rem ? 32'(sa % sb) : 32'(sa / sb);
    else                                                   w = rem ? (a % b) : (a / b);
    return {{32{w[31]}}, w};
  endfunction

  function automatic int exp_lat(input logic [31:0] a, input logic [31:0] b, input logic sgn);
    if (b == 32'd0 || (sgn && a == 32'h8000_0000 && b == 32'hFFFF_FFFF)) return 1;
    return 33;
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // start an operation at a falling edge, wait for done, report latency
  task automatic run_op(input logic [31:0] a, input logic [31:0] b, input logic rem,
                        input logic sgn, output logic [63:0] res, output int lat);
    @(negedge clk);
    op_a_i = a; op_b_i = b; want_rem_i = rem; signed_i = sgn; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    res = result_o;
  endtask

  initial begin
    #1_500_000;
    n_fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end

  initial begin
    logic [63:0] res, held;
    int lat;
    start_i = 1'b0; op_a_i = '0; op_b_i = '0; want_rem_i = 1'b0; signed_i = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R8: reset state
    check(busy_o == 1'b0 && done_o == 1'b0 && result_o == 64'd0, "R8 reset",
          {62'd0, busy_o, done_o} | result_o, 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // table walk: R3 R4 R5 R6 R7 R2
    for (int i = 0; i < NV; i++) begin
      logic [31:0] a, b;
      logic rm, sg;
      {a, b, rm, sg} = VECS[i];
      run_op(a, b, rm, sg, res, lat);
      check(res == model(a, b, rm, sg),
            rm ? "R4/R5/R6/R7 remainder" : "R3/R5/R6/R7 quotient", res, model(a, b, rm, sg));
      check(lat == exp_lat(a, b, sg), "R2/R5/R6 latency", 64'(lat), 64'(exp_lat(a, b, sg)));
    end

    // R1: busy in the cycle after a regular accept; start while busy is ignored
    @(negedge clk);
    op_a_i = 32'd1000; op_b_i = 32'd3; want_rem_i = 1'b0; signed_i = 1'b0; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(busy_o == 1'b1, "R1 busy after accept", 64'(busy_o), 64'd1);
    repeat (3) @(negedge clk);
    op_a_i = 32'd5; op_b_i = 32'd0; want_rem_i = 1'b1; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    check(done_o == 1'b0 && busy_o == 1'b1, "R1 start ignored while busy",
          {62'd0, busy_o, done_o}, 64'd2);
    lat = 5;
    while (!done_o && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    check(lat == 33, "R1 ignored start does not shorten run", 64'(lat), 64'd33);
    check(result_o == 64'd333, "R1 result of first request kept", result_o, 64'd333);

    // R8: done pulse and hold
    held = result_o;
    @(negedge clk);
    check(done_o == 1'b0, "R8 done single cycle", 64'(done_o), 64'd0);
    repeat (5) @(negedge clk);
    check(result_o == held && busy_o == 1'b0, "R8 result held", result_o, held);

    // R7: unsigned result with bit 31 set widens with ones
    run_op(32'hF000_0000, 32'd1, 1'b0, 1'b0, res, lat);
    check(res == 64'hFFFF_FFFF_F000_0000, "R7 unsigned widening", res, 64'hFFFF_FFFF_F000_0000);

    // R5 then regular back-to-back: fixed answer then normal run
    run_op(32'hDEAD_BEEF, 32'd0, 1'b0, 1'b0, res, lat);
    check(res == 64'hFFFF_FFFF_8000_0000 && lat == 1, "R5 zero divisor unsigned quotient",
          res, 64'hFFFF_FFFF_8000_0000);
    run_op(-32'sd9, 32'd4, 1'b1, 1'b1, res, lat);
    check(res == 64'hFFFF_FFFF_FFFF_FFFF, "R4 remainder sign follows dividend",
          res, 64'hFFFF_FFFF_FFFF_FFFF);

    $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
    $finish;
  end
endmodule